// File: doc/BRIEF.md
# Serial Peripheral Port with Mode-Fault Supervision

This block is a one-word SPI port that a local host programs through a small register file. The host selects master or slave operation, enables the port, and then writes a byte to transmit and reads the received byte. In master mode the block generates the serial clock from the system clock. In slave mode it follows an external clock and select line, and both are passed through synchronisers before use. Frames are 8 bits, sent MSB first, in clock mode 0: the clock idles low, data is sampled on the rising edge and shifted on the falling edge.

The port also supervises the slave select. If the select line is released in the middle of a slave frame, a sticky fault flag is raised. That flag can drive an error interrupt. It never disables the port by itself. Clearing the enable bit performs a partial reset: a slave frame in flight is dropped, a master frame in flight is allowed to finish, and the data registers keep their contents.

Top module: `spi_mf_ctrl`

## Requirements
- R1: After reset the control register reads 0, the status register reads 0x02 (only transmit-empty set), `ss_o` is 1, `miso_oe` is 0 and `irq_err` is 0.
- R2: Register map, read combinationally on `reg_rdata`:
  - address 0 is control: bit 0 enable, bit 1 master, bit 2 error-interrupt enable, bit 3 fault enable.
  - address 1 is status: bit 0 fault, bit 1 transmit-empty, bit 2 receive-full.
  - address 2 is transmit data.
  - address 3 is receive data.

  When the port is enabled as master, writing address 2 starts a frame. During the frame `ss_o` is low. The byte leaves on `mosi_o` MSB first, with 8 rising edges of `sclk_o` spaced 2*CLK_DIV clocks apart. `sclk_o` is 0 whenever `ss_o` is high. The byte sampled from `miso_i` lands in the receive register.
- R3: When a frame completes, the received byte is stored and receive-full is set. Taking a byte for transmission sets transmit-empty.
- R4: As an enabled slave, the port shifts in `mosi_i` on synchronised rising edges of `sclk_i` while `ss_i` is low, and presents the transmit byte MSB first on `miso_o`. While `ss_i` is high, `miso_oe` is 0 and `sclk_i` edges are ignored.
- R5: In slave mode with fault enable set, `ss_i` going high after at least one bit of a frame sets the fault flag. The control register is left unchanged.
- R6: Writing 1 to status bit 0 clears the fault flag only when no fault condition is present. While the interrupted frame's partial bit count remains, the flag stays set. Once the port is disabled, the write clears it.
- R7: `irq_err` is 1 exactly when the fault flag, error-interrupt enable, fault enable and enable are all 1.
- R8: While enable is 0, transmit-empty reads 1 and an unfinished slave frame is discarded, so the next frame after re-enabling starts from bit 0.
- R9: Clearing enable during a master frame lets that frame finish and deliver its received byte. No further frame starts while enable is 0.
- R10: The transmit and receive data registers keep their contents while enable is 0. Only `rst_n` clears them.
- R11: Reading address 3 with `reg_rd` high clears receive-full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on address 3) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| irq_err | output | 1 | Error interrupt request |
| sclk_o | output | 1 | Serial clock out (master) |
| mosi_o | output | 1 | Serial data out (master) |
| ss_o | output | 1 | Select out, active low (master) |
| miso_i | input | 1 | Serial data in (master) |
| sclk_i | input | 1 | Serial clock in (slave) |
| mosi_i | input | 1 | Serial data in (slave) |
| ss_i | input | 1 | Select in, active low (slave) |
| miso_o | output | 1 | Serial data out (slave) |
| miso_oe | output | 1 | Output enable for `miso_o` |

## Verification
Master frames run through a loopback in two forms. A straight loopback returns the sent byte. An inverted loopback returns its complement, which separates real sampling from a design that merely copies transmit to receive. Slave frames are preceded by stray clock edges with the select high, so a design that counts those edges corrupts the received byte. The fault sequence first interrupts a slave frame midway, then toggles each interrupt gate, tries a clear under the fault condition and again after disabling. The final complete frame shows whether the abort really reset the bit position.

// File: rtl/spi_mf_pkg.sv
// Shared definitions for the SPI port: register addresses and bit positions.
package spi_mf_pkg;

    typedef enum logic [1:0] {
        RA_CTRL = 2'd0,
        RA_STAT = 2'd1,
        RA_TXD  = 2'd2,
        RA_RXD  = 2'd3
    } reg_addr_e;

    localparam int CB_EN  = 0;
    localparam int CB_MST = 1;
    localparam int CB_EIE = 2;
    localparam int CB_FEN = 3;

    localparam int SB_FLT = 0;
    localparam int SB_TXE = 1;
    localparam int SB_RXF = 2;

    typedef struct packed {
        logic fault_en;
        logic err_ie;
        logic master;
        logic en;
    } ctrl_t;

endpackage

// File: rtl/spi_mf_sync.sv
// Multi-stage synchroniser for a vector of asynchronous inputs.
// Assumes each bit is independent; RST_VAL gives the idle level per bit.
module spi_mf_sync #(
    parameter int         W       = 3,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Shift the input one flop further along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else if (g == 0) stage_q[g] <= d_i;
                else stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/spi_mf_regs.sv
// Host register file: control bits, fault/transmit/receive flags, data words.
// Assumes single-cycle write and read strobes; reads are combinational.
module spi_mf_regs
    import spi_mf_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          fault_cond,
    input  logic          tx_taken,
    input  logic          rx_done,
    input  logic [DW-1:0] rx_word,
    output ctrl_t         ctrl,
    output logic          fault_flag,
    output logic [DW-1:0] tx_data,
    output logic          tx_empty,
    output logic          rx_full,
    output logic          irq_err
);

    logic [DW-1:0] rx_data;
    logic          wr_ctrl, wr_stat, wr_txd, rd_rxd;

    assign wr_ctrl = reg_wr && (reg_addr == RA_CTRL);
    assign wr_stat = reg_wr && (reg_addr == RA_STAT);
    assign wr_txd  = reg_wr && (reg_addr == RA_TXD);
    assign rd_rxd  = reg_rd && (reg_addr == RA_RXD);

    // Control register update.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl <= '0;
        else if (wr_ctrl) begin
            ctrl.en       <= reg_wdata[CB_EN];
            ctrl.master   <= reg_wdata[CB_MST];
            ctrl.err_ie   <= reg_wdata[CB_EIE];
            ctrl.fault_en <= reg_wdata[CB_FEN];
        end
    end

    // Sticky fault flag: set wins, write-one clears only with no live condition.
    always_ff @(posedge clk) begin
        if (!rst_n) fault_flag <= 1'b0;
        else if (fault_cond) fault_flag <= 1'b1;
        else if (wr_stat && reg_wdata[SB_FLT]) fault_flag <= 1'b0;
    end

    // Transmit word and empty flag; forced empty while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_data  <= '0;
            tx_empty <= 1'b1;
        end else begin
            if (wr_txd) tx_data <= reg_wdata;
            if (!ctrl.en) tx_empty <= 1'b1;
            else if (wr_txd) tx_empty <= 1'b0;
            else if (tx_taken) tx_empty <= 1'b1;
        end
    end

    // Receive word and full flag; completion wins over a read clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data <= '0;
            rx_full <= 1'b0;
        end else if (rx_done) begin
            rx_data <= rx_word;
            rx_full <= 1'b1;
        end else if (rd_rxd) begin
            rx_full <= 1'b0;
        end
    end

    // Read data multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CTRL: begin
                reg_rdata[CB_EN]  = ctrl.en;
                reg_rdata[CB_MST] = ctrl.master;
                reg_rdata[CB_EIE] = ctrl.err_ie;
                reg_rdata[CB_FEN] = ctrl.fault_en;
            end
            RA_STAT: begin
                reg_rdata[SB_FLT] = fault_flag;
                reg_rdata[SB_TXE] = tx_empty;
                reg_rdata[SB_RXF] = rx_full;
            end
            RA_TXD:  reg_rdata = tx_data;
            default: reg_rdata = rx_data;
        endcase
    end

    assign irq_err = fault_flag && ctrl.err_ie && ctrl.fault_en && ctrl.en;

endmodule

// File: rtl/spi_mf_master.sv
// Master engine: mode-0 frame of DW bits, SCLK half period HALF_DIV clocks.
// Assumes start only when idle; a running frame always completes.
module spi_mf_master #(
    parameter int DW       = 8,
    parameter int HALF_DIV = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] load_data,
    input  logic          miso_i,
    output logic          busy,
    output logic          sclk_o,
    output logic          mosi_o,
    output logic          done,
    output logic [DW-1:0] rx_word
);

    localparam int DIV_W  = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam int EDGES  = 2 * DW;
    localparam int EDGE_W = $clog2(EDGES);
    localparam logic [DIV_W-1:0]  DIV_LAST  = DIV_W'(HALF_DIV - 1);
    localparam logic [EDGE_W-1:0] EDGE_LAST = EDGE_W'(EDGES - 1);

    logic [DW-1:0]     shift_q;
    logic [DIV_W-1:0]  div_cnt;
    logic [EDGE_W-1:0] edge_cnt;
    logic              rx_bit;
    logic              tick;

    assign tick    = busy && (div_cnt == DIV_LAST);
    assign done    = tick && sclk_o && (edge_cnt == EDGE_LAST);
    assign rx_word = {shift_q[DW-2:0], rx_bit};
    assign mosi_o  = shift_q[DW-1];

    // Clock divider, edge sequencing, sample on rise and shift on fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            sclk_o   <= 1'b0;
            shift_q  <= '0;
            div_cnt  <= '0;
            edge_cnt <= '0;
            rx_bit   <= 1'b0;
        end else if (start && !busy) begin
            busy     <= 1'b1;
            sclk_o   <= 1'b0;
            shift_q  <= load_data;
            div_cnt  <= '0;
            edge_cnt <= '0;
        end else if (busy) begin
            if (tick) begin
                div_cnt  <= '0;
                sclk_o   <= ~sclk_o;
                edge_cnt <= edge_cnt + 1'b1;
                if (!sclk_o) rx_bit <= miso_i;
                else shift_q <= {shift_q[DW-2:0], rx_bit};
                if (done) busy <= 1'b0;
            end else begin
                div_cnt <= div_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/spi_mf_slave.sv
// Slave engine: synchronises SCLK/MOSI/SS, mode-0 shifting, abort on disable.
// Assumes SCLK is slow enough for the synchroniser (several clocks per phase).
module spi_mf_slave #(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          sclk_i,
    input  logic          mosi_i,
    input  logic          ss_i,
    output logic          miso_o,
    output logic          miso_oe,
    output logic          done,
    output logic [DW-1:0] rx_word,
    output logic          in_progress,
    output logic          ss_high
);

    localparam int CNT_W = $clog2(DW + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DW);

    logic [2:0]       sync_q;
    logic             sclk_s, mosi_s, sclk_prev;
    logic             active, rise, fall;
    logic [CNT_W-1:0] bit_cnt;
    logic [DW-1:0]    shift_q;
    logic             rx_bit;

    spi_mf_sync #(
        .W      (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  ({ss_i, mosi_i, sclk_i}),
        .q_o  (sync_q)
    );

    assign sclk_s      = sync_q[0];
    assign mosi_s      = sync_q[1];
    assign ss_high     = sync_q[2];
    assign active      = enable && !ss_high;
    assign rise        = active && sclk_s && !sclk_prev;
    assign fall        = active && !sclk_s && sclk_prev;
    assign done        = fall && (bit_cnt == CNT_FULL);
    assign rx_word     = {shift_q[DW-2:0], rx_bit};
    assign in_progress = (bit_cnt != '0);
    assign miso_o      = shift_q[DW-1];
    assign miso_oe     = active;

    // Remember the previous synchronised clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_prev <= 1'b0;
        else sclk_prev <= sclk_s;
    end

    // Bit counter: cleared by disable (abort) or frame completion.
    always_ff @(posedge clk) begin
        if (!rst_n) bit_cnt <= '0;
        else if (!enable) bit_cnt <= '0;
        else if (done) bit_cnt <= '0;
        else if (rise) bit_cnt <= bit_cnt + 1'b1;
    end

    // Sample on rise, shift on fall, preload when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
            rx_bit  <= 1'b0;
        end else begin
            if (rise) rx_bit <= mosi_s;
            if (load) shift_q <= load_data;
            else if (fall) shift_q <= {shift_q[DW-2:0], rx_bit};
        end
    end

endmodule

// File: rtl/spi_mf_ctrl.sv
// SPI port top: register file, master and slave engines, fault detection.
// Assumes one direction of operation at a time, selected by the master bit.
module spi_mf_ctrl
    import spi_mf_pkg::*;
#(
    parameter int DW          = 8,
    parameter int CLK_DIV     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq_err,
    output logic          sclk_o,
    output logic          mosi_o,
    output logic          ss_o,
    input  logic          miso_i,
    input  logic          sclk_i,
    input  logic          mosi_i,
    input  logic          ss_i,
    output logic          miso_o,
    output logic          miso_oe
);

    ctrl_t         ctrl;
    logic          fault_flag, fault_cond;
    logic [DW-1:0] tx_data, m_word, s_word, rx_word;
    logic          tx_empty, rx_full, tx_taken, rx_done;
    logic          m_start, m_busy, m_done;
    logic          s_load, s_done, s_in_progress, s_ss_high;

    // Fault: slave released mid-frame with fault supervision enabled.
    assign fault_cond = ctrl.en && !ctrl.master && ctrl.fault_en && s_ss_high && s_in_progress;
    assign m_start    = ctrl.en && ctrl.master && !tx_empty && !m_busy;
    assign s_load     = ctrl.en && !ctrl.master && !tx_empty && !s_in_progress;
    assign tx_taken   = m_start || s_load;
    assign rx_done    = m_done || s_done;
    assign rx_word    = m_done ? m_word : s_word;
    assign ss_o       = !m_busy;

    spi_mf_regs #(.DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .fault_cond(fault_cond),
        .tx_taken  (tx_taken),
        .rx_done   (rx_done),
        .rx_word   (rx_word),
        .ctrl      (ctrl),
        .fault_flag(fault_flag),
        .tx_data   (tx_data),
        .tx_empty  (tx_empty),
        .rx_full   (rx_full),
        .irq_err   (irq_err)
    );

    spi_mf_master #(.DW(DW), .HALF_DIV(CLK_DIV)) u_master (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (m_start),
        .load_data(tx_data),
        .miso_i   (miso_i),
        .busy     (m_busy),
        .sclk_o   (sclk_o),
        .mosi_o   (mosi_o),
        .done     (m_done),
        .rx_word  (m_word)
    );

    spi_mf_slave #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_slave (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (ctrl.en && !ctrl.master),
        .load       (s_load),
        .load_data  (tx_data),
        .sclk_i     (sclk_i),
        .mosi_i     (mosi_i),
        .ss_i       (ss_i),
        .miso_o     (miso_o),
        .miso_oe    (miso_oe),
        .done       (s_done),
        .rx_word    (s_word),
        .in_progress(s_in_progress),
        .ss_high    (s_ss_high)
    );

endmodule

// File: rtl/spi_mf_checker.sv
// Temporal checks on the SPI port; attached to the top by bind below.
module spi_mf_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic       master,
    input logic       reg_wr,
    input logic [1:0] reg_addr,
    input logic       wdata0,
    input logic       fault_cond,
    input logic       fault_flag,
    input logic       tx_empty,
    input logic       rx_full,
    input logic       ss_o,
    input logic       miso_oe,
    input logic       m_busy,
    input logic       m_done,
    input logic       s_done
);

    // R2: a master frame begins exactly when the transmit word is taken.
    a_r2_start_takes_word: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ss_o) |-> $rose(tx_empty));

    // R3: every completed frame leaves receive-full set.
    a_r3_done_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
        (m_done || s_done) |=> rx_full);

    // R4: MISO is only driven by an enabled slave.
    a_r4_oe_slave_only: assert property (@(posedge clk) disable iff (!rst_n)
        miso_oe |-> (en && !master));

    // R5: a live fault condition raises the flag.
    a_r5_fault_sets: assert property (@(posedge clk) disable iff (!rst_n)
        fault_cond |=> fault_flag);

    // R6: a clear attempt during a live condition leaves the flag set.
    a_r6_clear_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd1 && wdata0 && fault_cond) |=> fault_flag);

    // R8: disabled port reports transmit-empty.
    a_r8_off_txe: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> tx_empty);

    // R9: a master frame is never cut short.
    a_r9_master_runs: assert property (@(posedge clk) disable iff (!rst_n)
        (m_busy && !m_done) |=> m_busy);

endmodule

bind spi_mf_ctrl spi_mf_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (ctrl.en),
    .master    (ctrl.master),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .wdata0    (reg_wdata[0]),
    .fault_cond(fault_cond),
    .fault_flag(fault_flag),
    .tx_empty  (tx_empty),
    .rx_full   (rx_full),
    .ss_o      (ss_o),
    .miso_oe   (miso_oe),
    .m_busy    (m_busy),
    .m_done    (m_done),
    .s_done    (s_done)
);

// File: tb/spi_mf_ctrl_bench.sv
module spi_mf_ctrl_bench;

    localparam int DW   = 8;
    localparam int DIV  = 4;
    localparam int HALF = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          irq_err, sclk_o, mosi_o, ss_o, miso_i, miso_o, miso_oe;
    logic          sclk_i = 1'b0, mosi_i = 1'b0, ss_i = 1'b1;
    logic          lb_inv = 1'b0;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int ss_hi_cnt = 0;
    int last_rise = -1;
    int ss_falls  = 0;
    logic prev_ss_o = 1'b1;
    logic mq[$];

    always #5 clk = ~clk;

    assign miso_i = lb_inv ? ~mosi_o : mosi_o;

    spi_mf_ctrl #(.DW(DW), .CLK_DIV(DIV)) u_spi_mf_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_err(irq_err), .sclk_o(sclk_o), .mosi_o(mosi_o), .ss_o(ss_o),
        .miso_i(miso_i), .sclk_i(sclk_i), .mosi_i(mosi_i), .ss_i(ss_i),
        .miso_o(miso_o), .miso_oe(miso_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_frame_end();
        int n;
        n = 0;
        while (ss_o && n < 50) begin @(negedge clk); n++; end
        n = 0;
        while (!ss_o && n < 2000) begin @(negedge clk); n++; end
    endtask

    task automatic slave_bits(input logic [7:0] mo, input int nb, output logic [7:0] mi);
        mi = '0;
        @(negedge clk);
        ss_i = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            mosi_i = mo[7-i];
            repeat (HALF) @(negedge clk);
            mi[7-i] = miso_o;
            sclk_i = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk_i = 1'b0;
        end
        repeat (HALF) @(negedge clk);
    endtask

    task automatic release_ss();
        ss_i = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    // Per-clock reference comparison of behaviour visible at the pins.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (ss_i) ss_hi_cnt++; else ss_hi_cnt = 0;
            if (ss_hi_cnt >= 4) chk("R4 miso_oe with ss high", miso_oe, 1'b0);
            if (ss_o) begin
                chk("R2 sclk idle low", sclk_o, 1'b0);
                last_rise = -1;
            end
            if (prev_ss_o && !ss_o) ss_falls++;
            prev_ss_o = ss_o;
        end
    end

    // Record master data at each SCLK rise and check rise spacing.
    always @(posedge sclk_o) begin
        mq.push_back(mosi_o);
        if (last_rise >= 0) chk("R2 sclk period", cyc - last_rise, 2 * DIV);
        last_rise = cyc;
    end

    function automatic logic [7:0] mq_byte();
        logic [7:0] b;
        b = '0;
        foreach (mq[i]) if (i < 8) b[7-i] = mq[i];
        return b;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] d, mi;
        int falls0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, d); chk("R1 ctrl reset", d, 8'h00);
        rd(2'd1, d); chk("R1 status reset", d, 8'h02);
        chk("R1 ss_o reset", ss_o, 1'b1);
        chk("R1 miso_oe reset", miso_oe, 1'b0);
        chk("R1 irq reset", irq_err, 1'b0);

        // R2/R3 master straight loopback
        wr(2'd0, 8'h03);
        mq.delete();
        wr(2'd2, 8'hA5);
        wait_frame_end();
        chk("R2 rise count", mq.size(), 8);
        chk("R2 mosi bits", mq_byte(), 8'hA5);
        rd(2'd1, d); chk("R3 status after master frame", d, 8'h07 & 8'h06);
        rd(2'd3, d); chk("R2 rx loopback", d, 8'hA5);
        rd(2'd1, d); chk("R11 rx_full cleared by read", d[2], 1'b0);

        // R2 master inverted loopback
        lb_inv = 1'b1;
        mq.delete();
        wr(2'd2, 8'h3C);
        wait_frame_end();
        chk("R2 mosi bits inv", mq_byte(), 8'h3C);
        rd(2'd3, d); chk("R2 rx inverted loopback", d, 8'hC3);
        lb_inv = 1'b0;

        // R9 disable during a master frame
        wr(2'd2, 8'h81);
        repeat (20) @(negedge clk);
        chk("R9 frame running", ss_o, 1'b0);
        wr(2'd0, 8'h02);
        wait_frame_end();
        rd(2'd1, d); chk("R9 status after finish", d, 8'h06);
        wr(2'd2, 8'h11);
        falls0 = ss_falls;
        repeat (60) @(negedge clk);
        chk("R9 no new frame while disabled", ss_falls - falls0, 0);
        rd(2'd1, d); chk("R8 txe held while disabled", d[1], 1'b1);
        rd(2'd2, d); chk("R10 tx kept while disabled", d, 8'h11);
        rd(2'd3, d); chk("R9 rx of finished frame", d, 8'h81);

        // R4 slave ignores SCLK with SS high, then a full frame
        wr(2'd0, 8'h0D);
        wr(2'd2, 8'h96);
        for (int k = 0; k < 5; k++) begin
            mosi_i = 1'b1;
            repeat (HALF) @(negedge clk); sclk_i = 1'b1;
            repeat (HALF) @(negedge clk); sclk_i = 1'b0;
        end
        rd(2'd1, d); chk("R4 no fault from ignored edges", d[0], 1'b0);
        slave_bits(8'h3C, 8, mi);
        release_ss();
        chk("R4 miso bits", mi, 8'h96);
        rd(2'd3, d); chk("R4 rx after ignored edges", d, 8'h3C);

        // R4 second slave pattern
        wr(2'd2, 8'hF0);
        slave_bits(8'h0F, 8, mi);
        release_ss();
        chk("R4 miso bits 2", mi, 8'hF0);
        rd(2'd1, d); chk("R3 rx_full after slave frame", d[2], 1'b1);
        rd(2'd3, d); chk("R4 rx 2", d, 8'h0F);

        // R5..R8 mode fault sequence
        wr(2'd2, 8'h55);
        slave_bits(8'hFF, 3, mi);
        release_ss();
        rd(2'd1, d); chk("R5 fault flag set", d[0], 1'b1);
        rd(2'd0, d); chk("R5 ctrl unchanged by fault", d, 8'h0D);
        chk("R7 irq with all gates", irq_err, 1'b1);
        wr(2'd1, 8'h01);
        rd(2'd1, d); chk("R6 clear blocked by live fault", d[0], 1'b1);
        wr(2'd0, 8'h09);
        @(negedge clk); chk("R7 irq off by err_ie", irq_err, 1'b0);
        wr(2'd0, 8'h05);
        @(negedge clk); chk("R7 irq off by fault_en", irq_err, 1'b0);
        wr(2'd0, 8'h0D);
        @(negedge clk); chk("R7 irq back on", irq_err, 1'b1);
        wr(2'd0, 8'h0C);
        @(negedge clk); chk("R7 irq off by disable", irq_err, 1'b0);
        rd(2'd1, d); chk("R8 txe when disabled", d[1], 1'b1);
        wr(2'd1, 8'h01);
        rd(2'd1, d); chk("R6 clear after disable", d[0], 1'b0);
        wr(2'd0, 8'h0D);
        rd(2'd3, d); chk("R10 rx kept over partial reset", d, 8'h0F);
        wr(2'd2, 8'h5A);
        slave_bits(8'hC6, 8, mi);
        release_ss();
        chk("R8 miso after abort", mi, 8'h5A);
        rd(2'd3, d); chk("R8 rx restarts from bit 0", d, 8'hC6);
        rd(2'd1, d); chk("R6 no fault after clean frame", d[0], 1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule